// File: doc/BRIEF.md
# Four-Bank Interleaved Block Memory Controller

This block serves whole four-word blocks from storage split across four banks. Each bank is one word wide. Word `i` of every block sits in bank `i mod 4`. A request carries a block address and a direction. The controller spends one cycle presenting the address to all four banks at once. All banks then run their access together, so the bank latency is paid only once per block.

On a read, the four words come back one per cycle over a single word-wide bus, in bank order, each marked by a valid strobe. On a write, the whole block arrives with the request, and each bank stores its own word in parallel with the others. A `done` pulse marks the last cycle of every transfer. `busy` stays high from the cycle after the request is taken until the transfer ends. Any request that arrives while `busy` is high is dropped.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, `busy`, `rdValid` and `done` are low.
- R2: A block read returns exactly four words in the order bank 0, 1, 2, 3. The word delivered at position `i` is the one last written at slot `i` of that block, taken from `wrBlock[i*DATA_W +: DATA_W]`.
- R3: For a read whose `start` is sampled at clock edge 0, the words appear with `rdValid` high in cycles 17, 18, 19 and 20. Cycle `k` is the cycle after edge `k-1`. `done` is high in cycle 20 only. This gives 1 address cycle, 15 bank cycles and 4 bus cycles.
- R4: A block read takes 1 + BANK_LAT + 4 cycles, which is 20 by default. The same block on one word-wide memory would take 1 + 4×BANK_LAT + 4 = 65 cycles. The interleaved count is therefore lower by 3×BANK_LAT.
- R5: For a block write, `done` is high in cycle 16 only and `rdValid` never rises. All four words are stored during the same clock edge.
- R6: `busy` is high in every cycle from 1 to the `done` cycle, and low in the cycle after it. A `start` seen while `busy` is high starts no transfer and writes nothing.
- R7: `rdValid` is high only while `busy` is high, for exactly four cycles per read and zero per write.
- R8: A write changes only the addressed block. Every other block reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| wrEn | input | 1 | 1 = block write, 0 = block read (sampled with start) |
| blkAddr | input | BLK_ADDR_W | Block address |
| wrBlock | input | NUM_BANKS*DATA_W | Write block; word i in bits [i*DATA_W +: DATA_W] |
| busy | output | 1 | Transfer in progress |
| rdData | output | DATA_W | Read word on the shared bus |
| rdValid | output | 1 | rdData holds a read word |
| done | output | 1 | Last cycle of a transfer |

## Verification
A table of blocks is written and read back. It includes block address 0 and the highest address. Each block carries a different data seed, so every word encodes its block and position. A swapped word order or a wrong bank would therefore show up as a mismatch, not as a plausible value. The cycle of each word and of `done` is measured against the 20-cycle and 16-cycle figures and compared with the 65-cycle serial cost.

Three directed cases follow. One overwrites a block between two neighbours, to separate address decoding from bank selection. One injects a write request into the middle of a read, to show that the request changes neither the stream nor the stored data. The last checks the reset state.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;
  localparam int NUM_BANKS = 4;
  localparam int SEL_W = $clog2(NUM_BANKS);

  // Strobes from control to datapath
  typedef struct packed {
    logic             latchReq;   // capture address and write block
    logic             bankRead;   // all banks capture their word
    logic             bankWrite;  // all banks store their word
    logic [SEL_W-1:0] wordSel;    // bank driving the bus
  } ctrl_strobes_t;
endpackage

// File: rtl/ilv_mem_bank.sv
module ilv_mem_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrWord,
  input  logic              rdStb,
  output logic [DATA_W-1:0] rdWord
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrStb) store[addr] <= wrWord;
    if (rdStb) rdWord <= store[addr];
  end
endmodule

// File: rtl/ilv_mem_datapath.sv
module ilv_mem_datapath
  import ilv_mem_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BLK_ADDR_W = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrl_strobes_t               stb,
  input  logic                        rdValid,
  input  logic [BLK_ADDR_W-1:0]       blkAddr,
  input  logic [NUM_BANKS*DATA_W-1:0] wrBlock,
  output logic [DATA_W-1:0]           rdData
);
  logic [BLK_ADDR_W-1:0]       addrQ;
  logic [NUM_BANKS*DATA_W-1:0] wrQ;
  logic [DATA_W-1:0]           bankOut [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      wrQ   <= '0;
    end else if (stb.latchReq) begin
      addrQ <= blkAddr;
      wrQ   <= wrBlock;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_mem_bank #(.DATA_W(DATA_W), .ADDR_W(BLK_ADDR_W)) u_bank (
      .clk   (clk),
      .addr  (addrQ),
      .wrStb (stb.bankWrite),
      .wrWord(wrQ[b*DATA_W +: DATA_W]),
      .rdStb (stb.bankRead),
      .rdWord(bankOut[b])
    );
  end

  assign rdData = bankOut[stb.wordSel];

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.bankRead, stb.bankWrite}));

  // R2
  word_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && stb.wordSel != SEL_W'(NUM_BANKS-1)) |=>
      (rdValid && stb.wordSel == $past(stb.wordSel) + SEL_W'(1)));

  // R2
  first_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> (stb.wordSel == '0));
endmodule

// File: rtl/ilv_mem_control.sv
module ilv_mem_control
  import ilv_mem_pkg::*;
#(
  parameter int BANK_LAT = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          wrEn,
  output ctrl_strobes_t stb,
  output logic          busy,
  output logic          rdValid,
  output logic          done
);
  localparam int LAT_W    = $clog2(BANK_LAT + 1);
  localparam int RD_TOTAL = 1 + BANK_LAT + NUM_BANKS;
  localparam int WR_TOTAL = 1 + BANK_LAT;
  localparam int CNT_W    = $clog2(RD_TOTAL + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_ACCESS, ST_XFER} state_t;

  state_t           state;
  logic [LAT_W-1:0] latCnt;
  logic [SEL_W-1:0] beat;
  logic             isWrite;
  logic             accessEnd;

  assign accessEnd = (state == ST_ACCESS) && (latCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      latCnt  <= '0;
      beat    <= '0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          isWrite <= wrEn;
          state   <= ST_SEND;
        end
        ST_SEND: begin
          latCnt <= LAT_W'(BANK_LAT - 1);
          state  <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (latCnt == '0) begin
            beat  <= '0;
            state <= isWrite ? ST_IDLE : ST_XFER;
          end else begin
            latCnt <= latCnt - LAT_W'(1);
          end
        end
        ST_XFER: begin
          if (beat == SEL_W'(NUM_BANKS-1)) state <= ST_IDLE;
          else beat <= beat + SEL_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.latchReq  = (state == ST_IDLE) && start;
    stb.bankRead  = accessEnd && !isWrite;
    stb.bankWrite = accessEnd && isWrite;
    stb.wordSel   = beat;
  end

  assign busy    = (state != ST_IDLE);
  assign rdValid = (state == ST_XFER);
  assign done    = ((state == ST_XFER) && (beat == SEL_W'(NUM_BANKS-1)))
                 || stb.bankWrite;

  // Checker-side cycle count since the request was taken
  logic [CNT_W-1:0] elapsed;
  always_ff @(posedge clk) begin
    if (!rstN) elapsed <= '0;
    else if (!busy) elapsed <= (start ? CNT_W'(1) : '0);
    else if (elapsed != '1) elapsed <= elapsed + CNT_W'(1);
  end

  // R3
  rd_done_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && rdValid) |-> (elapsed == CNT_W'(RD_TOTAL)));

  // R5
  wr_done_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !rdValid) |-> (elapsed == CNT_W'(WR_TOTAL)));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R6
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R7
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> busy);
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
  import ilv_mem_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BLK_ADDR_W = 6,
  parameter int BANK_LAT   = 15
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        wrEn,
  input  logic [BLK_ADDR_W-1:0]       blkAddr,
  input  logic [NUM_BANKS*DATA_W-1:0] wrBlock,
  output logic                        busy,
  output logic [DATA_W-1:0]           rdData,
  output logic                        rdValid,
  output logic                        done
);
  ctrl_strobes_t stb;

  ilv_mem_control #(.BANK_LAT(BANK_LAT)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .wrEn   (wrEn),
    .stb    (stb),
    .busy   (busy),
    .rdValid(rdValid),
    .done   (done)
  );

  ilv_mem_datapath #(.DATA_W(DATA_W), .BLK_ADDR_W(BLK_ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdValid(rdValid),
    .blkAddr(blkAddr),
    .wrBlock(wrBlock),
    .rdData (rdData)
  );
endmodule

// File: tb/ilv_mem_ctrl_bench.sv
module ilv_mem_ctrl_bench;
  localparam int DW  = 32;
  localparam int AW  = 6;
  localparam int LAT = 15;
  localparam int NB  = 4;
  localparam int NV  = 6;

  // Stimulus table: block address, data seed
  localparam logic [AW-1:0] VEC_ADDR [NV] = '{6'd0, 6'd20, 6'd21, 6'd22, 6'd37, 6'd63};
  localparam logic [7:0]    VEC_SEED [NV] = '{8'h11, 8'h5A, 8'hC3, 8'h7E, 8'h02, 8'hF0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] blkAddr = '0;
  logic [NB*DW-1:0] wrBlock = '0;
  logic busy, rdValid, done;
  logic [DW-1:0] rdData;

  always #4 clk = ~clk;

  ilv_mem_ctrl #(.DATA_W(DW), .BLK_ADDR_W(AW), .BANK_LAT(LAT)) u_ilv_mem_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn), .blkAddr(blkAddr),
    .wrBlock(wrBlock), .busy(busy), .rdData(rdData), .rdValid(rdValid), .done(done)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Results of the last transfer
  int doneCycle;
  int validCnt;
  int wordCycle [NB];
  logic [DW-1:0] wordGot [NB];
  bit busyGap;
  bit wrongDone;

  function automatic logic [DW-1:0] wordOf(logic [7:0] seed, logic [AW-1:0] blk, int i);
    logic [15:0] mix;
    mix = 16'(seed) * 16'd97 + 16'(i) * 16'd13 + 16'(blk);
    return {seed, blk, 2'(i), mix};
  endfunction

  function automatic logic [NB*DW-1:0] blockOf(logic [7:0] seed, logic [AW-1:0] blk);
    logic [NB*DW-1:0] b;
    for (int i = 0; i < NB; i++) b[i*DW +: DW] = wordOf(seed, blk, i);
    return b;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one transfer. At cycle pokeAt (>0) a write request to pokeAddr is injected.
  task automatic runBlock(bit isWr, logic [AW-1:0] addr, logic [NB*DW-1:0] data,
                          int pokeAt, logic [AW-1:0] pokeAddr);
    int cyc;
    @(negedge clk);
    start = 1'b1; wrEn = isWr; blkAddr = addr; wrBlock = data;
    @(negedge clk);
    start = 1'b0; wrEn = 1'b0;
    cyc = 1; doneCycle = 0; validCnt = 0; busyGap = 0; wrongDone = 0;
    for (int i = 0; i < NB; i++) begin wordCycle[i] = 0; wordGot[i] = '0; end
    while (cyc < 60) begin
      if (!busy) busyGap = 1;
      if (rdValid) begin
        if (validCnt < NB) begin
          wordGot[validCnt] = rdData;
          wordCycle[validCnt] = cyc;
        end
        validCnt++;
      end
      if (done) begin
        if (doneCycle != 0) wrongDone = 1;
        doneCycle = cyc;
        break;
      end
      @(negedge clk);
      start = 1'b0; wrEn = 1'b0;
      cyc++;
      if (cyc == pokeAt) begin
        start = 1'b1; wrEn = 1'b1; blkAddr = pokeAddr;
        wrBlock = blockOf(8'hEE, pokeAddr);
      end
    end
    // one cycle after done: must be idle
    @(negedge clk);
    start = 1'b0;
    if (done) wrongDone = 1;
    check(!busy, "R6", "busy after done", busy, 0);
  endtask

  task automatic readAndCheck(logic [AW-1:0] addr, logic [7:0] seed, int pokeAt,
                              logic [AW-1:0] pokeAddr);
    runBlock(1'b0, addr, '0, pokeAt, pokeAddr);
    for (int i = 0; i < NB; i++) begin
      check(wordGot[i] == wordOf(seed, addr, i), "R2", "word value", wordGot[i], wordOf(seed, addr, i));
      check(wordCycle[i] == 17 + i, "R3", "word cycle", wordCycle[i], 17 + i);
    end
    check(doneCycle == 20, "R3", "read done cycle", doneCycle, 20);
    check(validCnt == NB, "R7", "valid count read", validCnt, NB);
    check(!busyGap, "R6", "busy gap in read", busyGap, 0);
    check(!wrongDone, "R3", "done not single", wrongDone, 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!busy && !rdValid && !done, "R1", "outputs in reset", {busy, rdValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !rdValid && !done, "R1", "outputs after reset", {busy, rdValid, done}, 0);

    // Table: write every block (R5)
    for (int v = 0; v < NV; v++) begin
      runBlock(1'b1, VEC_ADDR[v], blockOf(VEC_SEED[v], VEC_ADDR[v]), 0, '0);
      check(doneCycle == 16, "R5", "write done cycle", doneCycle, 16);
      check(validCnt == 0, "R7", "valid during write", validCnt, 0);
      check(!busyGap, "R6", "busy gap in write", busyGap, 0);
      check(!wrongDone, "R5", "write done not single", wrongDone, 0);
    end
    // Table: read every block back (R2, R3, R7)
    for (int v = 0; v < NV; v++) readAndCheck(VEC_ADDR[v], VEC_SEED[v], 0, '0);

    // R4: interleaved versus serial cost
    runBlock(1'b0, VEC_ADDR[1], '0, 0, '0);
    check(doneCycle == 1 + LAT + NB, "R4", "interleaved total", doneCycle, 1 + LAT + NB);
    check(doneCycle < 1 + NB*LAT + NB, "R4", "below serial 65", doneCycle, 1 + NB*LAT + NB);
    check((1 + NB*LAT + NB) - doneCycle == 3*LAT, "R4", "saving", (1 + NB*LAT + NB) - doneCycle, 3*LAT);

    // R8: overwrite middle block, neighbours unchanged
    runBlock(1'b1, VEC_ADDR[2], blockOf(8'h99, VEC_ADDR[2]), 0, '0);
    readAndCheck(VEC_ADDR[2], 8'h99, 0, '0);
    readAndCheck(VEC_ADDR[1], VEC_SEED[1], 0, '0);
    readAndCheck(VEC_ADDR[3], VEC_SEED[3], 0, '0);

    // R6: write request injected mid-read to block 22 is ignored
    readAndCheck(VEC_ADDR[4], VEC_SEED[4], 5, VEC_ADDR[3]);
    repeat (3) begin
      @(negedge clk);
      check(!busy, "R6", "no transfer from ignored start", busy, 0);
    end
    readAndCheck(VEC_ADDR[3], VEC_SEED[3], 0, '0);

    // R1: reset mid-transfer returns to idle
    @(negedge clk);
    start = 1'b1; wrEn = 1'b0; blkAddr = VEC_ADDR[0];
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check(!busy && !rdValid && !done, "R1", "outputs after mid reset", {busy, rdValid, done}, 0);

    finished = 1'b1;
    finishRun();
  end
endmodule